// File: doc/BRIEF.md
# Performance Monitor Counter Unit

This block counts processor activity for profiling and debug. Four 32-bit event counters each follow one line of a 30-bit event bus, picked by a per-counter 8-bit type code. The one exception is type 0x00, which counts only increments written by software. A fifth 32-bit counter tracks clock cycles, either on every clock or once every 64 clocks. Software programs and reads every register over an APB slave port.

Each counter has an enable, an interrupt enable and an overflow flag. A counter sets its overflow flag when it wraps to zero. A single active-high interrupt line reports any flagged counter whose interrupt is enabled. A global enable in the control register starts and stops all counting and gates the interrupt. A separate control bit passes the event bus out through an export port.

Top module: `perf_mon_unit`

## Requirements
- R1: After reset, all counters, enables, interrupt enables and overflow flags are zero, `ovf_irq` is 0 and `event_export` is 0.
- R2: An event counter advances by one on each clock edge at which its selected event line is high, the global enable (control bit 0) is 1 and its own enable is 1. Otherwise it holds.
- R3: Type codes map to event bus bits as follows: 0x01–0x10 select bits 0–15, 0x12–0x15 select bits 16–19, 0x86 selects bit 20, 0x87 selects bit 21, 0xC0–0xC6 select bits 22–28 and 0xC9 selects bit 29. Every other nonzero code counts nothing.
- R4: A counter of type 0x00 ignores the event bus. It advances once when a 1 is written to its bit (bit i for counter i) at offset 0xCA0, but only if it is enabled and the global enable is 1.
- R5: Writing 1s at 0xC00 sets enables and writing 1s at 0xC20 clears them. Bits 0–3 are the event counters and bit 31 is the cycle counter. Zero bits have no effect, and both offsets read back the current enables. The interrupt enables at 0xC40 and 0xC60 work the same way.
- R6: Writing control bit 1 clears the four event counters and leaves the cycle counter alone. Writing control bit 2 clears only the cycle counter and its prescaler. Both bits read back as 0.
- R7: When the global enable and bit 31 are set, the cycle counter (offset 0x07C) advances every clock if control bit 3 is 0, and on every 64th enabled clock if it is 1.
- R8: A counter that wraps from 0xFFFFFFFF to 0 sets its overflow flag at 0xC80, using the same bit positions as R5. Writing 1 to a flag clears it.
- R9: `ovf_irq` is 1 exactly when the global enable is 1 and some counter has both its overflow flag and its interrupt enable set.
- R10: `event_export` equals `event_bus` when control bit 4 is 1, and is zero otherwise.
- R11: When an APB write to a counter (offsets 0x000–0x00C, 0x07C) lands in the same cycle as an increment, the written value is kept.
- R12: The control register at 0xE04 reads 0x5A in bits [31:24], 0x03 in bits [23:16] and 4 in bits [15:11]. Bits [10:5] read 0 and ignore writes. The type registers at 0x400–0x40C read back the written code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Clock |
| presetn | input | 1 | Synchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when 1 |
| paddr | input | 12 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data, combinational from address |
| event_bus | input | 30 | Event lines from the processor |
| event_export | output | 30 | Gated copy of the event bus |
| ovf_irq | output | 1 | Overflow interrupt, active high |

## Verification
A register write takes effect at the clock edge that ends its APB access phase. Read data is combinational, so the bench samples `prdata` within that access phase, after the settling delay from the falling edge. An event line held high across N rising edges adds exactly N. The interrupt and the export port follow their register state combinationally, so they are checked one step after the edge that changed that state. For the cycle counter, the bench counts the rising edges between the enabling write and the disabling write and derives the expected value from that count (23 in the fast case, 128/64 = 2 in the divided case).

// File: rtl/perf_mon_pkg.sv
// Package: shared widths, register offsets and event-type decoding for the
// performance monitor. Assumes a 30-bit event bus indexed by 5 bits.
package perf_mon_pkg;
    localparam int CNT_W     = 32;
    localparam int TYPE_W    = 8;
    localparam int ADDR_W    = 12;
    localparam int EVT_BUS_W = 30;
    localparam int IDX_W     = 5;

    localparam logic [ADDR_W-1:0] OFF_EVT_CNT = 12'h000;
    localparam logic [ADDR_W-1:0] OFF_CYC_CNT = 12'h07C;
    localparam logic [ADDR_W-1:0] OFF_TYPE    = 12'h400;
    localparam logic [ADDR_W-1:0] OFF_EN_SET  = 12'hC00;
    localparam logic [ADDR_W-1:0] OFF_EN_CLR  = 12'hC20;
    localparam logic [ADDR_W-1:0] OFF_IE_SET  = 12'hC40;
    localparam logic [ADDR_W-1:0] OFF_IE_CLR  = 12'hC60;
    localparam logic [ADDR_W-1:0] OFF_OVF     = 12'hC80;
    localparam logic [ADDR_W-1:0] OFF_SWINC   = 12'hCA0;
    localparam logic [ADDR_W-1:0] OFF_CTRL    = 12'hE04;

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
    } evt_sel_t;

    // Maps a type code to an event bus position; valid=0 means count nothing.
    function automatic evt_sel_t decode_type(input logic [TYPE_W-1:0] t);
        evt_sel_t s;
        s.valid = 1'b1;
        s.idx   = '0;
        if (t >= 8'h01 && t <= 8'h10)      s.idx = IDX_W'(t - 8'h01);
        else if (t >= 8'h12 && t <= 8'h15) s.idx = IDX_W'(t - 8'h02);
        else if (t == 8'h86)               s.idx = IDX_W'(20);
        else if (t == 8'h87)               s.idx = IDX_W'(21);
        else if (t >= 8'hC0 && t <= 8'hC6) s.idx = IDX_W'(t - 8'hAA);
        else if (t == 8'hC9)               s.idx = IDX_W'(29);
        else                               s.valid = 1'b0;
        return s;
    endfunction
endpackage

// File: rtl/pm_event_select.sv
// Event select: turns one counter's type code into a per-cycle hit from the
// event bus, and flags the software-increment type. Purely combinational.
module pm_event_select
    import perf_mon_pkg::*;
#(
    parameter int BUS_W = EVT_BUS_W
) (
    input  logic [TYPE_W-1:0] type_i,
    input  logic [BUS_W-1:0]  bus_i,
    output logic              hit_o,
    output logic              swinc_o
);
    localparam int PAD_W = 2 ** IDX_W;

    evt_sel_t          sel;
    logic [PAD_W-1:0]  bus_pad;

    // Decode the type and pick the selected event line.
    always_comb begin
        sel     = decode_type(type_i);
        bus_pad = {{(PAD_W-BUS_W){1'b0}}, bus_i};
        hit_o   = sel.valid & bus_pad[sel.idx];
        swinc_o = (type_i == '0);
    end
endmodule

// File: rtl/pm_prescale.sv
// Prescaler: issues the cycle counter's advance strobe, either every running
// clock or every 2**DIV_LOG2 running clocks. Assumes clr_i restarts the phase.
module pm_prescale #(
    parameter int DIV_LOG2 = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic run_i,
    input  logic div_i,
    output logic tick_o
);
    logic [DIV_LOG2-1:0] phase;

    // Phase counter advances only while running in divided mode.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) phase <= '0;
        else if (run_i && div_i) phase <= phase + 1'b1;
    end

    assign tick_o = run_i & (~div_i | (&phase));

    // R7: in divided mode two strobes are never adjacent.
    a_r7_sparse_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && div_i && !clr_i) |=> (!tick_o || !div_i));
endmodule

// File: rtl/pm_counter.sv
// Counter: one 32-bit counter with software write, clear and increment.
// Priority write > clear > increment; wrap_o pulses on a wrap to zero.
module pm_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o,
    output logic         wrap_o
);
    // Count register update.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_o <= '0;
        else if (wr_i)  cnt_o <= wdata_i;
        else if (clr_i) cnt_o <= '0;
        else if (inc_i) cnt_o <= cnt_o + 1'b1;
    end

    assign wrap_o = inc_i & ~wr_i & ~clr_i & (&cnt_o);

    // R11: a software write always lands.
    a_r11_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (cnt_o == $past(wdata_i)));
    // R8: a wrap leaves the counter at zero.
    a_r8_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> (cnt_o == '0));
    // R2: no cause, no change.
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_i && !clr_i && !inc_i) |=> $stable(cnt_o));
endmodule

// File: rtl/perf_mon_unit.sv
// Top: APB-programmed performance monitor with NUM_EVT event counters, one
// cycle counter, enable/interrupt/overflow bit registers and event export.
// Assumes APB without wait states; writes commit at the access-phase edge.
module perf_mon_unit
    import perf_mon_pkg::*;
#(
    parameter int          NUM_EVT  = 4,
    parameter int          BUS_W    = EVT_BUS_W,
    parameter int          DIV_LOG2 = 6,
    parameter logic [7:0]  IMPL_ID  = 8'h5A,
    parameter logic [7:0]  PART_ID  = 8'h03
) (
    input  logic              pclk,
    input  logic              presetn,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [CNT_W-1:0]  pwdata,
    output logic [CNT_W-1:0]  prdata,
    input  logic [BUS_W-1:0]  event_bus,
    output logic [BUS_W-1:0]  event_export,
    output logic              ovf_irq
);
    localparam int CYC_BIT = 31;
    localparam int GAP_W   = CYC_BIT - NUM_EVT;

    logic                wr_stb;
    logic                ctrl_en, ctrl_div, ctrl_exp;
    logic                wr_ctrl, wr_swinc, clr_evt, clr_cyc;
    logic [NUM_EVT-1:0]  evt_en, evt_ie, evt_ovf, evt_wrap;
    logic                cyc_en, cyc_ie, cyc_ovf, cyc_wrap, cyc_tick;
    logic [TYPE_W-1:0]   evt_type [NUM_EVT];
    logic [CNT_W-1:0]    evt_cnt  [NUM_EVT];
    logic [CNT_W-1:0]    cyc_cnt;

    assign wr_stb   = psel & penable & pwrite;
    assign wr_ctrl  = wr_stb && (paddr == OFF_CTRL);
    assign wr_swinc = wr_stb && (paddr == OFF_SWINC);
    assign clr_evt  = wr_ctrl & pwdata[1];
    assign clr_cyc  = wr_ctrl & pwdata[2];

    // Control register bits.
    always_ff @(posedge pclk) begin
        if (!presetn) begin
            ctrl_en  <= 1'b0;
            ctrl_div <= 1'b0;
            ctrl_exp <= 1'b0;
        end else if (wr_ctrl) begin
            ctrl_en  <= pwdata[0];
            ctrl_div <= pwdata[3];
            ctrl_exp <= pwdata[4];
        end
    end

    // Count-enable and interrupt-enable set/clear registers.
    always_ff @(posedge pclk) begin
        if (!presetn) begin
            evt_en <= '0; cyc_en <= 1'b0;
            evt_ie <= '0; cyc_ie <= 1'b0;
        end else if (wr_stb) begin
            if (paddr == OFF_EN_SET) begin
                evt_en <= evt_en | pwdata[NUM_EVT-1:0];
                cyc_en <= cyc_en | pwdata[CYC_BIT];
            end
            if (paddr == OFF_EN_CLR) begin
                evt_en <= evt_en & ~pwdata[NUM_EVT-1:0];
                cyc_en <= cyc_en & ~pwdata[CYC_BIT];
            end
            if (paddr == OFF_IE_SET) begin
                evt_ie <= evt_ie | pwdata[NUM_EVT-1:0];
                cyc_ie <= cyc_ie | pwdata[CYC_BIT];
            end
            if (paddr == OFF_IE_CLR) begin
                evt_ie <= evt_ie & ~pwdata[NUM_EVT-1:0];
                cyc_ie <= cyc_ie & ~pwdata[CYC_BIT];
            end
        end
    end

    // Overflow flags: a wrap sets, a write of 1 clears; a wrap wins.
    always_ff @(posedge pclk) begin
        if (!presetn) begin
            evt_ovf <= '0;
            cyc_ovf <= 1'b0;
        end else begin
            for (int i = 0; i < NUM_EVT; i++) begin
                if (evt_wrap[i]) evt_ovf[i] <= 1'b1;
                else if (wr_stb && paddr == OFF_OVF && pwdata[i]) evt_ovf[i] <= 1'b0;
            end
            if (cyc_wrap) cyc_ovf <= 1'b1;
            else if (wr_stb && paddr == OFF_OVF && pwdata[CYC_BIT]) cyc_ovf <= 1'b0;
        end
    end

    // One event counter with its type register and selector per slot.
    for (genvar gi = 0; gi < NUM_EVT; gi++) begin : g_evt
        localparam logic [ADDR_W-1:0] CNT_OFF  = ADDR_W'(OFF_EVT_CNT + 4*gi);
        localparam logic [ADDR_W-1:0] TYPE_OFF = ADDR_W'(OFF_TYPE + 4*gi);
        logic hit, swinc, inc;

        // Event type register.
        always_ff @(posedge pclk) begin
            if (!presetn) evt_type[gi] <= '0;
            else if (wr_stb && paddr == TYPE_OFF) evt_type[gi] <= pwdata[TYPE_W-1:0];
        end

        pm_event_select #(.BUS_W(BUS_W)) u_sel (
            .type_i (evt_type[gi]),
            .bus_i  (event_bus),
            .hit_o  (hit),
            .swinc_o(swinc)
        );

        assign inc = ctrl_en & evt_en[gi] &
                     (swinc ? (wr_swinc & pwdata[gi]) : hit);

        pm_counter #(.W(CNT_W)) u_cnt (
            .clk    (pclk),
            .rst_n  (presetn),
            .wr_i   (wr_stb && paddr == CNT_OFF),
            .wdata_i(pwdata),
            .clr_i  (clr_evt),
            .inc_i  (inc),
            .cnt_o  (evt_cnt[gi]),
            .wrap_o (evt_wrap[gi])
        );
    end

    pm_prescale #(.DIV_LOG2(DIV_LOG2)) u_pre (
        .clk   (pclk),
        .rst_n (presetn),
        .clr_i (clr_cyc),
        .run_i (ctrl_en & cyc_en),
        .div_i (ctrl_div),
        .tick_o(cyc_tick)
    );

    pm_counter #(.W(CNT_W)) u_cyc (
        .clk    (pclk),
        .rst_n  (presetn),
        .wr_i   (wr_stb && paddr == OFF_CYC_CNT),
        .wdata_i(pwdata),
        .clr_i  (clr_cyc),
        .inc_i  (cyc_tick),
        .cnt_o  (cyc_cnt),
        .wrap_o (cyc_wrap)
    );

    // Read data multiplexer, combinational on the address.
    always_comb begin
        prdata = '0;
        case (paddr)
            OFF_CYC_CNT:             prdata = cyc_cnt;
            OFF_EN_SET, OFF_EN_CLR:  prdata = {cyc_en, {GAP_W{1'b0}}, evt_en};
            OFF_IE_SET, OFF_IE_CLR:  prdata = {cyc_ie, {GAP_W{1'b0}}, evt_ie};
            OFF_OVF:                 prdata = {cyc_ovf, {GAP_W{1'b0}}, evt_ovf};
            OFF_CTRL:                prdata = {IMPL_ID, PART_ID, 5'(NUM_EVT), 6'b0,
                                               ctrl_exp, ctrl_div, 2'b00, ctrl_en};
            default:                 prdata = '0;
        endcase
        for (int i = 0; i < NUM_EVT; i++) begin
            if (paddr == ADDR_W'(OFF_EVT_CNT + 4*i)) prdata = evt_cnt[i];
            if (paddr == ADDR_W'(OFF_TYPE + 4*i))    prdata = {{(CNT_W-TYPE_W){1'b0}}, evt_type[i]};
        end
    end

    // Interrupt and export outputs.
    assign ovf_irq      = ctrl_en & ((|(evt_ovf & evt_ie)) | (cyc_ovf & cyc_ie));
    assign event_export = ctrl_exp ? event_bus : '0;

    // R9: no interrupt without the global enable.
    a_r9_irq_gated: assert property (@(posedge pclk) disable iff (!presetn)
        ovf_irq |-> ctrl_en);
    // R10: export is silent while disabled.
    a_r10_export_off: assert property (@(posedge pclk) disable iff (!presetn)
        !ctrl_exp |-> (event_export == '0));
    // R6: event-counter clear reaches every event counter.
    a_r6_evt_clear: assert property (@(posedge pclk) disable iff (!presetn)
        clr_evt |=> (evt_cnt[0] == '0 && evt_cnt[NUM_EVT-1] == '0));
    // R6: cycle clear zeroes the cycle counter.
    a_r6_cyc_clear: assert property (@(posedge pclk) disable iff (!presetn)
        clr_cyc |=> (cyc_cnt == '0));
endmodule

// File: tb/perf_mon_unit_bench.sv
`timescale 1ns/1ps
module perf_mon_unit_bench;
    logic        pclk = 1'b0;
    logic        presetn = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic [29:0] event_bus = '0;
    logic [29:0] event_export;
    logic        ovf_irq;
    int          checks = 0;
    int          errors = 0;

    always #2.5 pclk = ~pclk;

    perf_mon_unit u_perf_mon_unit (
        .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .event_bus(event_bus), .event_export(event_export), .ovf_irq(ovf_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apb_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge pclk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
        @(negedge pclk); penable = 1;
        @(negedge pclk); psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic apb_rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge pclk); psel = 1; penable = 0; pwrite = 0; paddr = a;
        @(negedge pclk); penable = 1; #1 d = prdata;
        @(negedge pclk); psel = 0; penable = 0;
    endtask

    task automatic pulse_bus(input logic [29:0] v, input int n);
        @(negedge pclk); event_bus = v;
        repeat (n) @(negedge pclk);
        event_bus = '0;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        apb_rd(12'hE04, d); chk("R1/R12 ctrl after reset", d, 32'h5A03_2000);
        apb_rd(12'hC00, d); chk("R1 enables", d, 0);
        apb_rd(12'h000, d); chk("R1 counter0", d, 0);
        apb_rd(12'h07C, d); chk("R1 cycle counter", d, 0);
        chk("R1 irq", {31'b0, ovf_irq}, 0);
        chk("R1 export", {2'b0, event_export}, 0);
    endtask

    task automatic t_enable_regs;
        logic [31:0] d;
        apb_wr(12'hC00, 32'h8000_0005);
        apb_rd(12'hC00, d); chk("R5 set readback", d, 32'h8000_0005);
        apb_rd(12'hC20, d); chk("R5 clear-offset readback", d, 32'h8000_0005);
        apb_wr(12'hC20, 32'h0000_0004);
        apb_wr(12'hC00, 32'h0000_0000);
        apb_rd(12'hC00, d); chk("R5 after clear and zero set", d, 32'h8000_0001);
        apb_wr(12'hC20, 32'hFFFF_FFFF);
        apb_rd(12'hC00, d); chk("R5 all cleared", d, 0);
    endtask

    task automatic t_ctrl_fields;
        logic [31:0] d;
        apb_wr(12'hE04, 32'h0000_07C1);
        apb_rd(12'hE04, d); chk("R12 reserved bits ignored", d, 32'h5A03_2001);
        apb_wr(12'hE04, 32'h0000_0007);
        apb_rd(12'hE04, d); chk("R6 reset bits read 0", d, 32'h5A03_2001);
        apb_wr(12'h404, 32'h0000_00C9);
        apb_rd(12'h404, d); chk("R12 type readback", d, 32'h0000_00C9);
    endtask

    task automatic t_count;
        logic [31:0] d;
        apb_wr(12'h400, 32'h04);
        apb_wr(12'hC00, 32'h1);
        apb_wr(12'hE04, 32'h3);
        pulse_bus(30'h8, 7);
        apb_rd(12'h000, d); chk("R2 counts bit3", d, 7);
        apb_wr(12'hE04, 32'h0);
        pulse_bus(30'h8, 5);
        apb_rd(12'h000, d); chk("R2 holds when global off", d, 7);
        apb_wr(12'hE04, 32'h1);
        apb_wr(12'hC20, 32'h1);
        pulse_bus(30'h8, 5);
        apb_rd(12'h000, d); chk("R2 holds when counter off", d, 7);
    endtask

    task automatic t_mapping;
        logic [31:0] d;
        apb_wr(12'h400, 32'h12);
        apb_wr(12'h404, 32'h87);
        apb_wr(12'h408, 32'hC9);
        apb_wr(12'h40C, 32'h11);
        apb_wr(12'hC00, 32'hF);
        apb_wr(12'hE04, 32'h3);
        pulse_bus(30'h3FFF_FFFF, 5);
        apb_rd(12'h000, d); chk("R3 0x12 -> bit16", d, 5);
        apb_rd(12'h004, d); chk("R3 0x87 -> bit21", d, 5);
        apb_rd(12'h008, d); chk("R3 0xC9 -> bit29", d, 5);
        apb_rd(12'h00C, d); chk("R3 0x11 counts nothing", d, 0);
        pulse_bus(30'h0010_0000, 3);
        apb_rd(12'h004, d); chk("R3 bit20 not seen by 0x87", d, 5);
        pulse_bus(30'h0001_0000, 2);
        apb_rd(12'h000, d); chk("R3 bit16 alone", d, 7);
    endtask

    task automatic t_swinc;
        logic [31:0] d;
        apb_wr(12'hE04, 32'h3);
        apb_wr(12'h400, 32'h00);
        apb_wr(12'h404, 32'h00);
        pulse_bus(30'h3FFF_FFFF, 4);
        apb_rd(12'h000, d); chk("R4 bus ignored", d, 0);
        apb_wr(12'hCA0, 32'h1);
        apb_rd(12'h000, d); chk("R4 increment c0", d, 1);
        apb_rd(12'h004, d); chk("R4 c1 untouched", d, 0);
        apb_wr(12'hC20, 32'h1);
        apb_wr(12'hCA0, 32'h3);
        apb_rd(12'h000, d); chk("R4 disabled c0 holds", d, 1);
        apb_rd(12'h004, d); chk("R4 c1 increments", d, 1);
    endtask

    task automatic t_write_wins;
        logic [31:0] d;
        apb_wr(12'h400, 32'h04);
        apb_wr(12'hC00, 32'h1);
        apb_wr(12'hE04, 32'h1);
        @(negedge pclk); psel = 1; penable = 0; pwrite = 1; paddr = 12'h000;
        pwdata = 32'd100; event_bus = 30'h8;
        @(negedge pclk); penable = 1;
        @(negedge pclk); psel = 0; penable = 0; pwrite = 0; event_bus = '0;
        apb_rd(12'h000, d); chk("R11 write beats increment", d, 100);
    endtask

    task automatic t_overflow;
        logic [31:0] d;
        apb_wr(12'hE04, 32'h3);
        apb_wr(12'h400, 32'h00);
        apb_wr(12'hC00, 32'h1);
        apb_wr(12'h000, 32'hFFFF_FFFE);
        apb_wr(12'hCA0, 32'h1);
        apb_rd(12'h000, d); chk("R8 near wrap", d, 32'hFFFF_FFFF);
        apb_rd(12'hC80, d); chk("R8 no flag yet", d, 0);
        apb_wr(12'hCA0, 32'h1);
        apb_rd(12'h000, d); chk("R8 wrapped", d, 0);
        apb_rd(12'hC80, d); chk("R8 flag set", d, 1);
        chk("R9 no irq without enable", {31'b0, ovf_irq}, 0);
        apb_wr(12'hC40, 32'h1);
        #1 chk("R9 irq", {31'b0, ovf_irq}, 1);
        apb_wr(12'hE04, 32'h0);
        #1 chk("R9 irq gated by global", {31'b0, ovf_irq}, 0);
        apb_wr(12'hE04, 32'h1);
        #1 chk("R9 irq back", {31'b0, ovf_irq}, 1);
        apb_wr(12'hC80, 32'h1);
        #1 chk("R8 irq after flag clear", {31'b0, ovf_irq}, 0);
        apb_rd(12'hC80, d); chk("R8 flag cleared", d, 0);
        apb_wr(12'hC60, 32'h1);
    endtask

    task automatic t_cycle;
        logic [31:0] d;
        apb_wr(12'hC20, 32'hFFFF_FFFF);
        apb_wr(12'hE04, 32'h5);
        apb_wr(12'hC00, 32'h8000_0000);
        repeat (20) @(negedge pclk);
        apb_wr(12'hC20, 32'h8000_0000);
        apb_rd(12'h07C, d); chk("R7 every clock", d, 23);
        apb_wr(12'hE04, 32'hD);
        apb_wr(12'hC00, 32'h8000_0000);
        repeat (125) @(negedge pclk);
        apb_wr(12'hC20, 32'h8000_0000);
        apb_rd(12'h07C, d); chk("R7 divide by 64", d, 2);
    endtask

    task automatic t_resets;
        logic [31:0] d;
        apb_wr(12'h000, 32'd55);
        apb_wr(12'hE04, 32'h5);
        apb_rd(12'h07C, d); chk("R6 cycle cleared", d, 0);
        apb_rd(12'h000, d); chk("R6 event kept on cycle clear", d, 55);
        apb_wr(12'h07C, 32'd9);
        apb_wr(12'hE04, 32'h3);
        apb_rd(12'h000, d); chk("R6 event cleared", d, 0);
        apb_rd(12'h07C, d); chk("R6 cycle kept on event clear", d, 9);
    endtask

    task automatic t_export;
        apb_wr(12'hE04, 32'h1);
        @(negedge pclk); event_bus = 30'h2AAA_AAAA; #1;
        chk("R10 export off", {2'b0, event_export}, 0);
        event_bus = '0;
        apb_wr(12'hE04, 32'h11);
        @(negedge pclk); event_bus = 30'h1555_5555; #1;
        chk("R10 export on", {2'b0, event_export}, {2'b0, 30'h1555_5555});
        event_bus = '0;
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge pclk);
        presetn = 1;
        t_reset();
        t_enable_regs();
        t_ctrl_fields();
        t_count();
        t_mapping();
        t_swinc();
        t_write_wins();
        t_overflow();
        t_cycle();
        t_resets();
        t_export();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule